// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by software into asynchronous serial frames on one output line. A holding register accepts the next character while a separate shift register sends the current one. Software writes the holding register and then clears the data-empty flag to hand the character over. The block copies the character into the shift register and raises the data-empty flag again at once. As a result, a new character can be queued while the previous frame is still going out.

Each frame starts with one low bit and carries 7 or 8 data bits, least significant first. An optional extra bit follows the data: even parity, odd parity, or a multiprocessor flag taken from a configuration input. One or two high stop bits close the frame. At the end of the last stop bit the block checks the data-empty flag. If a character is waiting, the next frame begins with no idle gap. Otherwise the transmit-end flag is set and the line rests high. Bit timing comes from an external baud-tick enable, and each bit lasts 16 ticks.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset `txd` is 1, `empty_flag` is 1, `end_flag` is 1 and no frame is in progress.
- R2: Raising `empty_clr` while idle starts a frame. The start bit appears two clocks later, and `empty_flag` returns to 1 in the same clock that the start bit begins. Writing `hold_we` without `empty_clr` starts nothing and leaves `txd` and `empty_flag` at 1.
- R3: The frame is sent in this order: one 0 start bit, then the data bits least significant first, then the optional extra bit, then the stop bits at 1. There are 7 data bits when `cfg_short`=1 and 8 when it is 0. There are 2 stop bits when `cfg_two_stop`=1 and 1 when it is 0.
- R4: The extra bit is present only when `cfg_xbit_en`=1, and `cfg_xmode` selects its value. With 00 it is even parity, so the data bits plus this bit hold an even number of ones. With 01 it is odd parity. With 1x it is the `cfg_mp_bit` value. Parity covers only the data bits actually sent.
- R5: Every bit lasts exactly OSR (default 16) cycles in which `baud_tick` is 1. Without ticks, the line does not change.
- R6: If `empty_flag` is 0 at the end of the last stop bit, the next start bit follows immediately. Consecutive frame starts are then exactly one frame length apart, and `end_flag` stays 0.
- R7: If `empty_flag` is 1 at the end of the last stop bit, `end_flag` becomes 1 and `txd` stays 1 from then on.
- R8: `empty_clr` clears `end_flag`.
- R9: `txi_req` equals `empty_flag` AND `txi_en`, and `tei_req` equals `end_flag` AND `tei_en`. Both are levels.
- R10: The format inputs and `cfg_mp_bit` are captured when a character enters the shift register. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_we | input | 1 | Write strobe for the holding register |
| hold_wdata | input | 8 | Character to write |
| empty_clr | input | 1 | Clears the data-empty and transmit-end flags |
| cfg_short | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_xbit_en | input | 1 | Adds the extra bit after the data |
| cfg_xmode | input | 2 | 00 even parity, 01 odd parity, 1x multiprocessor bit |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_mp_bit | input | 1 | Value sent as the multiprocessor bit |
| baud_tick | input | 1 | Oversampling enable, OSR per bit |
| txi_en | input | 1 | Data-empty interrupt enable |
| tei_en | input | 1 | Transmit-end interrupt enable |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Data-empty flag |
| end_flag | output | 1 | Transmit-end flag |
| txi_req | output | 1 | Data-empty interrupt request |
| tei_req | output | 1 | Transmit-end interrupt request |

## Verification
Some rules are checked by the assertions on every cycle. The line stays high whenever no frame is active. Every frame opens with a low bit. The line changes only at the end of a bit period. The data-empty flag rises only when a character is copied into the shift register. The transmit-end flag is never set while a frame is in progress.

Other behaviour only the bench scenarios can show. These are the exact bit order and extra-bit value for every format combination, the 16-tick bit length under sparse ticks, and the gap-free chaining of a queued second frame. They also include the flag and interrupt levels around frame ends and the immunity of a frame to format changes made after it starts.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [1:0] {
        XB_EVEN  = 2'd0,
        XB_ODD   = 2'd1,
        XB_MP    = 2'd2,
        XB_MP_HI = 2'd3
    } xbit_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_XBIT,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic       short_char;
        logic       xbit_en;
        xbit_mode_e xmode;
        logic       two_stop;
        logic       mp_val;
    } frame_cfg_t;

    // Value of the bit that follows the data field
    function automatic logic xbit_calc(
        input logic [CHAR_W-1:0] d,
        input logic              short_char,
        input xbit_mode_e        m,
        input logic              mp
    );
        logic [CHAR_W-1:0] used;
        logic              par;
        logic              res;
        used = d;
        if (short_char) used[CHAR_W-1] = 1'b0;
        par = ^used;
        case (m)
            XB_EVEN: res = par;
            XB_ODD:  res = ~par;
            default: res = mp;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/dbtx_bit_timer.sv
module dbtx_bit_timer #(
    parameter int unsigned OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int unsigned CW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt;

    assign bit_end = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dbtx_serializer.sv
module dbtx_serializer
    import dbtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_end,
    input  logic              pending,
    input  logic [CHAR_W-1:0] hold_q,
    input  frame_cfg_t        cfg_in,
    output logic              txd,
    output logic              busy,
    output logic              load,
    output logic              done_idle
);
    localparam int unsigned IW = $clog2(CHAR_W);
    localparam logic [IW-1:0] LAST_FULL  = IW'(CHAR_W - 1);
    localparam logic [IW-1:0] LAST_SHORT = IW'(CHAR_W - 2);

    tx_state_e         state;
    logic [CHAR_W-1:0] shreg;
    logic [IW-1:0]     bit_idx;
    logic              stop_idx;
    logic              xbit_q;
    frame_cfg_t        cfg_q;

    logic          last_stop;
    logic [IW-1:0] last_data;

    assign last_data = cfg_q.short_char ? LAST_SHORT : LAST_FULL;
    assign last_stop = (state == ST_STOP) && (stop_idx == cfg_q.two_stop);
    assign load      = pending && ((state == ST_IDLE) || (last_stop && bit_end));
    assign done_idle = !pending && last_stop && bit_end;
    assign busy      = (state != ST_IDLE);

    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_XBIT:  txd = xbit_q;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            xbit_q   <= 1'b0;
            cfg_q    <= '0;
        end else if (load) begin
            state    <= ST_START;
            shreg    <= hold_q;
            cfg_q    <= cfg_in;
            xbit_q   <= xbit_calc(hold_q, cfg_in.short_char, cfg_in.xmode, cfg_in.mp_val);
            bit_idx  <= '0;
            stop_idx <= 1'b0;
        end else if (bit_end) begin
            case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    if (bit_idx == last_data) begin
                        state    <= cfg_q.xbit_en ? ST_XBIT : ST_STOP;
                        stop_idx <= 1'b0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= shreg >> 1;
                    end
                end
                ST_XBIT: begin
                    state    <= ST_STOP;
                    stop_idx <= 1'b0;
                end
                ST_STOP: begin
                    if (last_stop) state <= ST_IDLE;
                    else           stop_idx <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbtx_status.sv
module dbtx_status
    import dbtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_we,
    input  logic [CHAR_W-1:0] hold_wdata,
    input  logic              empty_clr,
    input  logic              load,
    input  logic              done_idle,
    input  logic              txi_en,
    input  logic              tei_en,
    output logic [CHAR_W-1:0] hold_q,
    output logic              empty_q,
    output logic              end_q,
    output logic              txi_req,
    output logic              tei_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
            end_q   <= 1'b1;
        end else begin
            if (hold_we) hold_q <= hold_wdata;
            if (load)           empty_q <= 1'b1;
            else if (empty_clr) empty_q <= 1'b0;
            if (empty_clr)      end_q <= 1'b0;
            else if (done_idle) end_q <= 1'b1;
        end
    end

    assign txi_req = empty_q && txi_en;
    assign tei_req = end_q && tei_en;
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import dbtx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_we,
    input  logic [CHAR_W-1:0] hold_wdata,
    input  logic              empty_clr,
    input  logic              cfg_short,
    input  logic              cfg_xbit_en,
    input  logic [1:0]        cfg_xmode,
    input  logic              cfg_two_stop,
    input  logic              cfg_mp_bit,
    input  logic              baud_tick,
    input  logic              txi_en,
    input  logic              tei_en,
    output logic              txd,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              txi_req,
    output logic              tei_req
);
    frame_cfg_t        cfg_in;
    logic [CHAR_W-1:0] hold_q;
    logic              tx_busy;
    logic              tx_load;
    logic              tx_done;
    logic              bit_end;
    logic              pending;

    assign cfg_in.short_char = cfg_short;
    assign cfg_in.xbit_en    = cfg_xbit_en;
    assign cfg_in.xmode      = xbit_mode_e'(cfg_xmode);
    assign cfg_in.two_stop   = cfg_two_stop;
    assign cfg_in.mp_val     = cfg_mp_bit;
    assign pending           = !empty_flag;

    dbtx_status i_status (
        .clk       (clk),
        .rst       (rst),
        .hold_we   (hold_we),
        .hold_wdata(hold_wdata),
        .empty_clr (empty_clr),
        .load      (tx_load),
        .done_idle (tx_done),
        .txi_en    (txi_en),
        .tei_en    (tei_en),
        .hold_q    (hold_q),
        .empty_q   (empty_flag),
        .end_q     (end_flag),
        .txi_req   (txi_req),
        .tei_req   (tei_req)
    );

    dbtx_bit_timer #(.OSR(OSR)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (tx_busy),
        .tick   (baud_tick),
        .bit_end(bit_end)
    );

    dbtx_serializer i_ser (
        .clk      (clk),
        .rst      (rst),
        .bit_end  (bit_end),
        .pending  (pending),
        .hold_q   (hold_q),
        .cfg_in   (cfg_in),
        .txd      (txd),
        .busy     (tx_busy),
        .load     (tx_load),
        .done_idle(tx_done)
    );
endmodule

// File: rtl/dbtx_chk.sv
module dbtx_chk (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic tx_busy,
    input logic tx_load,
    input logic bit_end,
    input logic empty_flag,
    input logic end_flag
);
    // R1 R7
    idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !txd);

    // R5
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !bit_end) |=> $stable(txd));

    // R2
    empty_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(empty_flag) |-> $past(tx_load));

    // R7
    end_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(end_flag) |-> empty_flag);

    // R6
    end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        end_flag |-> !tx_busy);
endmodule

bind dbuf_uart_tx dbtx_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .txd       (txd),
    .tx_busy   (tx_busy),
    .tx_load   (tx_load),
    .bit_end   (bit_end),
    .empty_flag(empty_flag),
    .end_flag  (end_flag)
);

// File: tb/test_dbuf_uart_tx.sv
module test_dbuf_uart_tx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hold_we = 1'b0;
    logic [7:0] hold_wdata = '0;
    logic       empty_clr = 1'b0;
    logic       cfg_short = 1'b0;
    logic       cfg_xbit_en = 1'b0;
    logic [1:0] cfg_xmode = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_mp_bit = 1'b0;
    logic       baud_tick = 1'b1;
    logic       txi_en = 1'b0;
    logic       tei_en = 1'b0;
    logic       txd, empty_flag, end_flag, txi_req, tei_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    dbuf_uart_tx i_dbuf_uart_tx (
        .clk(clk), .rst(rst), .hold_we(hold_we), .hold_wdata(hold_wdata),
        .empty_clr(empty_clr), .cfg_short(cfg_short), .cfg_xbit_en(cfg_xbit_en),
        .cfg_xmode(cfg_xmode), .cfg_two_stop(cfg_two_stop), .cfg_mp_bit(cfg_mp_bit),
        .baud_tick(baud_tick), .txi_en(txi_en), .tei_en(tei_en), .txd(txd),
        .empty_flag(empty_flag), .end_flag(end_flag), .txi_req(txi_req), .tei_req(tei_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int frame_len(input bit sh, input bit xe, input bit two);
        return 1 + (sh ? 7 : 8) + (xe ? 1 : 0) + (two ? 2 : 1);
    endfunction

    function automatic logic [15:0] frame_bits(input logic [7:0] d, input bit sh, input bit xe,
                                               input int mode, input bit mp);
        logic [15:0] v = '1;
        int n = 1;
        int ones = 0;
        v[0] = 1'b0;
        for (int i = 0; i < (sh ? 7 : 8); i++) begin
            v[n] = d[i];
            ones += d[i];
            n++;
        end
        if (xe) begin
            if (mode == 0)      v[n] = (ones % 2 == 1);
            else if (mode == 1) v[n] = (ones % 2 == 0);
            else                v[n] = mp;
        end
        return v;
    endfunction

    task automatic put_char(input logic [7:0] d);
        @(negedge clk);
        hold_we = 1'b1; hold_wdata = d; empty_clr = 1'b1;
        @(negedge clk);
        hold_we = 1'b0; empty_clr = 1'b0;
    endtask

    // Waits for a start bit (ticks every cycle), samples each bit mid-period
    task automatic capture(input int len, input bit scramble, input bit push, input logic [7:0] nxt,
                           output logic [15:0] got, output int t0);
        int guard = 0;
        got = '1;
        while (txd !== 1'b0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        t0 = cyc;
        if (scramble) begin
            cfg_short = ~cfg_short; cfg_xbit_en = ~cfg_xbit_en;
            cfg_xmode = cfg_xmode ^ 2'b01; cfg_two_stop = ~cfg_two_stop; cfg_mp_bit = ~cfg_mp_bit;
        end
        if (push) begin
            hold_we = 1'b1; hold_wdata = nxt; empty_clr = 1'b1;
        end
        @(negedge clk);
        hold_we = 1'b0; empty_clr = 1'b0;
        repeat (6) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < len; i++) begin
            repeat (16) @(negedge clk);
            got[i] = txd;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] got, got2, exp, exp2, mask;
        int t0, t1, len, len2, lowc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1 txd", txd, 1);
        chk(empty_flag === 1'b1, "R1 empty_flag", empty_flag, 1);
        chk(end_flag === 1'b1, "R1 end_flag", end_flag, 1);
        chk(txi_req === 1'b0 && tei_req === 1'b0, "R9 masked requests", {txi_req, tei_req}, 0);

        // R9 enables gate flags
        txi_en = 1'b1; tei_en = 1'b1;
        @(negedge clk);
        chk(txi_req === 1'b1 && tei_req === 1'b1, "R9 enabled requests", {txi_req, tei_req}, 3);
        txi_en = 1'b0;
        @(negedge clk);
        chk(txi_req === 1'b0, "R9 txi disabled", txi_req, 0);
        txi_en = 1'b1;

        // R2 holding write alone starts nothing
        @(negedge clk);
        hold_we = 1'b1; hold_wdata = 8'h00;
        @(negedge clk);
        hold_we = 1'b0;
        repeat (100) @(negedge clk);
        chk(txd === 1'b1 && empty_flag === 1'b1, "R2 write without clear", {txd, empty_flag}, 3);

        // Sweep of formats (R3 R4 R7 R8 R10 R2)
        for (int sh = 0; sh < 2; sh++)
        for (int xe = 0; xe < 2; xe++)
        for (int mode = 0; mode < 3; mode++)
        for (int two = 0; two < 2; two++)
        for (int di = 0; di < 4; di++) begin
            logic [7:0] d;
            d = 8'((di * 91 + mode * 17 + two * 44 + sh * 7 + xe * 130 + 163) % 256);
            cfg_short = sh[0]; cfg_xbit_en = xe[0]; cfg_xmode = 2'(mode);
            cfg_two_stop = two[0]; cfg_mp_bit = di[0];
            put_char(d);
            chk(end_flag === 1'b0, "R8 end cleared", end_flag, 0);
            len = frame_len(sh[0], xe[0], two[0]);
            exp = frame_bits(d, sh[0], xe[0], mode, di[0]);
            mask = 16'((32'd1 << len) - 1);
            capture(len, di[0], 1'b0, 8'h00, got, t0);
            chk(((got ^ exp) & mask) == 16'h0, di[0] ? "R10 R3 R4 frame with cfg change" : "R3 R4 frame",
                int'(got & mask), int'(exp & mask));
            repeat (9) @(negedge clk);
            chk(end_flag === 1'b1 && txd === 1'b1 && tei_req === 1'b1 && empty_flag === 1'b1,
                "R7 end of frame", {end_flag, txd, tei_req, empty_flag}, 15);
        end

        // R6 back-to-back frames
        cfg_short = 1'b0; cfg_xbit_en = 1'b1; cfg_xmode = 2'd1; cfg_two_stop = 1'b1; cfg_mp_bit = 1'b0;
        len = frame_len(1'b0, 1'b1, 1'b1);
        put_char(8'hC6);
        capture(len, 1'b0, 1'b1, 8'h39, got, t0);
        capture(len, 1'b0, 1'b0, 8'h00, got2, t1);
        mask = 16'((32'd1 << len) - 1);
        exp = frame_bits(8'hC6, 1'b0, 1'b1, 1, 1'b0);
        exp2 = frame_bits(8'h39, 1'b0, 1'b1, 1, 1'b0);
        chk(((got ^ exp) & mask) == 16'h0, "R6 first frame", int'(got & mask), int'(exp & mask));
        chk(((got2 ^ exp2) & mask) == 16'h0, "R6 second frame", int'(got2 & mask), int'(exp2 & mask));
        chk(t1 - t0 == 16 * len, "R6 no gap", t1 - t0, 16 * len);
        chk(end_flag === 1'b0, "R6 end held low", end_flag, 0);
        chk(txi_req === 1'b1, "R9 txi after reload", txi_req, 1);
        repeat (9) @(negedge clk);
        chk(end_flag === 1'b1, "R7 end after last", end_flag, 1);

        // R5 bit length with sparse ticks
        baud_tick = 1'b0;
        put_char(8'hFF);
        repeat (200) @(negedge clk);
        chk(txd === 1'b0, "R5 held without ticks", txd, 0);
        lowc = 0;
        for (int k = 0; k < 400; k++) begin
            if (txd !== 1'b0) break;
            lowc++;
            baud_tick = (k % 3 == 2);
            @(negedge clk);
        end
        chk(lowc == 48, "R5 start bit length", lowc, 48);
        baud_tick = 1'b1;
        for (int k = 0; k < 400 && end_flag !== 1'b1; k++) @(negedge clk);
        chk(end_flag === 1'b1 && txd === 1'b1, "R7 idle after sparse frame", {end_flag, txd}, 3);
        tei_en = 1'b0;
        @(negedge clk);
        chk(tei_req === 1'b0, "R9 tei disabled", tei_req, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule